// File: doc/BRIEF.md
# Battery Backup Control Register

This block is a memory-mapped control and status register for the backup supply of a non-volatile SRAM array. Software talks to it through a 32-bit write data bus with a single-cycle write strobe, and reads it through a 32-bit read data bus that reflects the current state at all times. The block senses a raw battery-OK level and a memory-type strap. It drives one pin that connects the battery to the SRAMs, or cuts it off.

Cutting the battery off is guarded. Software must write the disconnect bit twice in a row. The first write only arms the cut, and any write in between without that bit aborts the sequence. A separate reconnect bit restores the supply. A sticky status bit reports that the supply has been cut off.

The control core is a three-state machine. `ST_LINKED` means the battery is connected and nothing is armed. `ST_ARMED` means the battery is connected and one disconnect write has been seen. `ST_CUT` means the battery is disconnected. The transitions are as follows:
- `arm` goes from LINKED to ARMED on a write with bit 30 set and bit 29 clear.
- `cut` goes from ARMED to CUT on a write with bit 30 set and bit 29 clear.
- `abort` goes from ARMED to LINKED on a write with bit 30 clear.
- `relink` goes from ARMED or CUT to LINKED on any write with bit 29 set.
- `hold` keeps the current state in every other cycle.

Top module: `bbk_ctrl`

## Requirements
- R1: During and after reset, `bat_en` is 1, read bit 28 is 0 and nothing is armed. Reset during a disconnect restores the battery.
- R2: Read bit 31 returns `bat_ok_raw` after `SYNC_STAGES` clock edges of synchronization. 1 means the supply is good. The bit is meaningful only when read bit 1 is 0.
- R3: Read bit 1 shows `mem_type`. Read bits 30, 29, 27 to 10, 9 to 2 and 0 are always 0, including while the machine is armed.
- R4: A single write with bit 30 set and bit 29 clear, from the connected state, only arms. `bat_en` stays 1 and read bit 28 stays 0.
- R5: A second consecutive write with bit 30 set and bit 29 clear disconnects. On the clock edge that captures it, `bat_en` becomes 0 and read bit 28 becomes 1.
- R6: If the write after an arming write has bit 30 clear, the arm is cleared and the battery stays connected. A later write with bit 30 set then only arms again.
- R7: Clock cycles without a write leave the arm state unchanged.
- R8: A write with bit 29 set reconnects. `bat_en` returns to 1 and read bit 28 returns to 0 on that edge.
- R9: A write with both bit 30 and bit 29 set acts as a reconnect and clears any arm. The next write with bit 30 set only arms.
- R10: Writes to bits 31, 27 to 0 have no effect on the read value or on `bat_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, also power-up |
| csr_wr | input | 1 | Single-cycle write strobe |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Read data |
| bat_ok_raw | input | 1 | Asynchronous battery-OK level |
| mem_type | input | 1 | Memory-type strap; 0 means battery-backed SRAM |
| bat_en | output | 1 | Battery connect pin; 0 while disconnected |

## Verification
The bench builds the block with `SYNC_STAGES` set to 3 rather than the default of 2. This shows that the latency of read bit 31 follows the parameter rather than a fixed depth. The bench samples read bit 31 one edge early and then on the expected edge. The data width stays at 32 because the bit positions are part of the behaviour. That width lets the bench reach every reserved bit with a single all-ones pattern.

// File: rtl/bbk_pkg.sv
package bbk_pkg;
    localparam int BIT_OK    = 31;
    localparam int BIT_DIS   = 30;
    localparam int BIT_REEN  = 29;
    localparam int BIT_CUT   = 28;
    localparam int BIT_MTYPE = 1;

    typedef enum logic [1:0] {
        ST_LINKED = 2'd0,
        ST_ARMED  = 2'd1,
        ST_CUT    = 2'd2
    } bbk_state_e;
endpackage

// File: rtl/bbk_sync.sv
module bbk_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    generate
        if (STAGES <= 1) begin : g_single
            logic q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) q <= 1'b0;
                else        q <= din;
            end
            assign dout = q;
        end else begin : g_chain
            logic [STAGES-1:0] sh;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sh <= '0;
                else        sh <= {sh[STAGES-2:0], din};
            end
            assign dout = sh[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/bbk_fsm.sv
module bbk_fsm
    import bbk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr,
    input  logic dis_req,
    input  logic reen_req,
    output logic bat_en,
    output logic cut,
    output logic armed
);
    bbk_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_LINKED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (wr) begin
            unique case (state_q)
                ST_LINKED: begin
                    if (dis_req && !reen_req) state_d = ST_ARMED;
                end
                ST_ARMED: begin
                    if (reen_req)     state_d = ST_LINKED;
                    else if (dis_req) state_d = ST_CUT;
                    else              state_d = ST_LINKED;
                end
                ST_CUT: begin
                    if (reen_req) state_d = ST_LINKED;
                end
                default: state_d = ST_LINKED;
            endcase
        end
    end

    always_comb begin
        bat_en = 1'b1;
        cut    = 1'b0;
        armed  = 1'b0;
        unique case (state_q)
            ST_LINKED: ;
            ST_ARMED:  armed = 1'b1;
            ST_CUT: begin
                bat_en = 1'b0;
                cut    = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/bbk_readmux.sv
module bbk_readmux
    import bbk_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              ok_sync,
    input  logic              cut,
    input  logic              mtype,
    output logic [DATA_W-1:0] rdata
);
    always_comb begin
        rdata            = '0;
        rdata[BIT_OK]    = ok_sync;
        rdata[BIT_CUT]   = cut;
        rdata[BIT_MTYPE] = mtype;
    end
endmodule

// File: rtl/bbk_ctrl.sv
module bbk_ctrl
    import bbk_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csr_wr,
    input  logic [DATA_W-1:0] csr_wdata,
    output logic [DATA_W-1:0] csr_rdata,
    input  logic              bat_ok_raw,
    input  logic              mem_type,
    output logic              bat_en
);
    logic ok_sync;
    logic fsm_cut;
    logic fsm_armed;

    bbk_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (bat_ok_raw),
        .dout  (ok_sync)
    );

    bbk_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (csr_wr),
        .dis_req  (csr_wdata[BIT_DIS]),
        .reen_req (csr_wdata[BIT_REEN]),
        .bat_en   (bat_en),
        .cut      (fsm_cut),
        .armed    (fsm_armed)
    );

    bbk_readmux #(.DATA_W(DATA_W)) u_rmux (
        .ok_sync (ok_sync),
        .cut     (fsm_cut),
        .mtype   (mem_type),
        .rdata   (csr_rdata)
    );
endmodule

// File: rtl/bbk_ctrl_chk.sv
module bbk_ctrl_chk
    import bbk_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              csr_wr,
    input logic              dis_bit,
    input logic              reen_bit,
    input logic [DATA_W-1:0] csr_rdata,
    input logic              bat_en,
    input logic              armed
);
    localparam logic [DATA_W-1:0] LIVE_MASK =
        (DATA_W'(1) << BIT_OK) | (DATA_W'(1) << BIT_CUT) | (DATA_W'(1) << BIT_MTYPE);

    a_r3_zero_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_rdata & ~LIVE_MASK) == '0);

    a_r5_pin_vs_status: assert property (@(posedge clk) disable iff (!rst_n)
        bat_en == !csr_rdata[BIT_CUT]);

    a_r5_second_write_cuts: assert property (@(posedge clk) disable iff (!rst_n)
        armed && csr_wr && dis_bit && !reen_bit |=> !bat_en && csr_rdata[BIT_CUT]);

    a_r4_first_write_arms: assert property (@(posedge clk) disable iff (!rst_n)
        bat_en && !armed && csr_wr && dis_bit && !reen_bit |=> armed && bat_en);

    a_r6_abort: assert property (@(posedge clk) disable iff (!rst_n)
        armed && csr_wr && !dis_bit |=> !armed && bat_en);

    a_r7_idle_keeps_arm: assert property (@(posedge clk) disable iff (!rst_n)
        armed && !csr_wr |=> armed);

    a_r8_relink: assert property (@(posedge clk) disable iff (!rst_n)
        csr_wr && reen_bit |=> bat_en && !csr_rdata[BIT_CUT] && !armed);
endmodule

bind bbk_ctrl bbk_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .csr_wr    (csr_wr),
    .dis_bit   (csr_wdata[bbk_pkg::BIT_DIS]),
    .reen_bit  (csr_wdata[bbk_pkg::BIT_REEN]),
    .csr_rdata (csr_rdata),
    .bat_en    (bat_en),
    .armed     (fsm_armed)
);

// File: tb/test_bbk_ctrl.sv
`timescale 1ns/1ps
module test_bbk_ctrl;
    localparam int DW   = 32;
    localparam int SYNC = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          csr_wr = 1'b0;
    logic [DW-1:0] csr_wdata = '0;
    logic [DW-1:0] csr_rdata;
    logic          bat_ok_raw = 1'b0;
    logic          mem_type = 1'b0;
    logic          bat_en;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    bbk_ctrl #(.DATA_W(DW), .SYNC_STAGES(SYNC)) i_bbk_ctrl (
        .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .csr_wdata(csr_wdata),
        .csr_rdata(csr_rdata), .bat_ok_raw(bat_ok_raw), .mem_type(mem_type),
        .bat_en(bat_en)
    );

    // {wr, bit30, bit29, expected bat_en, expected bit28}
    localparam logic [4:0] TBL [12] = '{
        5'b11010, 5'b00010, 5'b11001, 5'b11001, 5'b10110, 5'b11010,
        5'b10010, 5'b11010, 5'b11110, 5'b11010, 5'b11001, 5'b11110
    };

    function automatic string row_tag(int i);
        case (i)
            0:       return "R4";
            1:       return "R7";
            2, 3:    return "R5";
            4:       return "R8";
            5, 6, 7: return "R6";
            10:      return "R5";
            default: return "R9";
        endcase
    endfunction

    task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // drive at a falling edge, return at the next falling edge
    task automatic step(logic wr, logic [DW-1:0] d);
        csr_wr    = wr;
        csr_wdata = d;
        @(negedge clk);
        csr_wr    = 1'b0;
        csr_wdata = '0;
    endtask

    localparam logic [DW-1:0] B30 = 32'h4000_0000;
    localparam logic [DW-1:0] B29 = 32'h2000_0000;

    initial begin
        for (int c = 0; c < 20000; c++) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset bat_en", DW'(bat_en), DW'(1));
        check("R1 reset rdata", csr_rdata, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset rdata", csr_rdata, '0);

        for (int i = 0; i < 12; i++) begin
            logic [DW-1:0] d;
            d = (TBL[i][3] ? B30 : '0) | (TBL[i][2] ? B29 : '0);
            step(TBL[i][4], d);
            check({row_tag(i), " table bat_en"}, DW'(bat_en), DW'(TBL[i][1]));
            check({row_tag(i), " table rdata"}, csr_rdata, DW'(TBL[i][0]) << 28);
        end

        // R3: armed state stays invisible in bits 30 and 29
        step(1'b1, B30);
        check("R3 armed readback", csr_rdata, '0);
        step(1'b1, '0);

        // R3 mem_type on bit 1
        mem_type = 1'b1;
        #1;
        check("R3 mem_type bit", csr_rdata, 32'h0000_0002);
        mem_type = 1'b0;

        // R10 writes to other bits ignored
        step(1'b1, 32'h9FFF_FFFF);
        check("R10 reserved write rdata", csr_rdata, '0);
        check("R10 reserved write bat_en", DW'(bat_en), DW'(1));
        step(1'b1, B30);
        step(1'b1, 32'h9FFF_FFFF);
        check("R10 reserved write aborts arm", DW'(bat_en), DW'(1));
        step(1'b1, B30);
        check("R10 rearm only", DW'(bat_en), DW'(1));
        step(1'b1, '0);

        // R2 synchronizer latency
        bat_ok_raw = 1'b1;
        for (int k = 1; k < SYNC; k++) @(negedge clk);
        check("R2 ok one edge early", DW'(csr_rdata[31]), DW'(0));
        @(negedge clk);
        check("R2 ok on time", DW'(csr_rdata[31]), DW'(1));
        bat_ok_raw = 1'b0;
        repeat (SYNC) @(negedge clk);
        check("R2 ok falls", DW'(csr_rdata[31]), DW'(0));

        // R1 reset while disconnected
        step(1'b1, B30);
        step(1'b1, B30);
        check("R5 cut before reset", DW'(bat_en), DW'(0));
        rst_n = 1'b0;
        #1;
        check("R1 reset restores pin", DW'(bat_en), DW'(1));
        check("R1 reset clears status", csr_rdata, '0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        step(1'b1, B30);
        check("R1 arm cleared by reset", DW'(bat_en), DW'(1));

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule